// File: doc/BRIEF.md
# Two-Wire Delta-Sigma Result Reader

This block sits on the host side of a two-wire link to a 16-bit delta-sigma converter. The host drives the serial clock, the converter drives the data line, and the converter's select pin is tied active, so no select signal exists. The block decides when a result is ready, clocks the result in, starts the next conversion, and hands each word to the rest of the chip on a parallel bus with a one-cycle valid strobe.

A static configuration input picks the resting level of the serial clock, and with it the ready scheme. With a high resting clock, the converter pulls the data line low when its result is ready. The block waits for that edge and then issues seventeen clock pulses: sixteen for data and one more that starts the next conversion. With a low resting clock, the data line gives no status, so the block waits for a fixed number of system cycles. It then issues sixteen pulses, and the last falling edge starts the next conversion. In the high-resting mode, a watchdog bound on the wait raises an error flag and forces a read if the ready edge never comes.

The serial clock runs at a fixed number of system cycles per half period. Data is captured on each rising serial clock edge, the opposite edge from the one on which the converter changes its output. The data line passes through a synchronizer before any use.

Top module: `adc2w_reader`

## Requirements
- R1: While reset is asserted, `sck` equals `idleHigh`, `dataValid` is 0, `dataOut` is 0 and `timeoutErr` is 0.
- R2: Each word is built most significant bit first from the data line value taken at each rising `sck` edge of a frame. When the frame ends, `dataOut` takes the new word and `dataValid` is 1 for exactly one cycle.
- R3: With `idleHigh`=1, a frame starts only after a high-to-low change on `sdIn` while waiting. A frame has 17 `sck` pulses, and the value taken at the 17th rising edge is not part of the word.
- R4: With `idleHigh`=0, a frame has 16 `sck` pulses. The first rising edge of the next frame comes exactly HALF_PERIOD + CONV_WAIT_CYCLES system cycles after the 16th falling edge, so no pulse reaches a converter that is still converting.
- R5: Inside a frame, every high and low phase of `sck` lasts exactly HALF_PERIOD system cycles.
- R6: Between frames `sck` rests at the level given by `idleHigh` (1 = high), and it is there when `dataValid` is asserted.
- R7: With `idleHigh`=1, if no falling edge on `sdIn` is seen within TIMEOUT_CYCLES cycles of the wait starting, the frame starts at that count, and `timeoutErr` is 1 when that frame's word is presented. A frame started by a detected edge clears `timeoutErr`. With `idleHigh`=0, `timeoutErr` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleHigh | input | 1 | Serial clock resting level: 1 = high with data-line ready detection, 0 = low with timed wait |
| sdIn | input | 1 | Serial data from the converter (asynchronous) |
| sck | output | 1 | Serial clock to the converter |
| dataOut | output | 16 | Last complete result word |
| dataValid | output | 1 | One-cycle strobe when `dataOut` is updated |
| timeoutErr | output | 1 | Ready edge missed within the bound (high-resting mode only) |

## Verification
The assertions assume that `idleHigh` changes only while reset is asserted. They also assume that `sdIn` changes only after a falling `sck` edge or at the end of a conversion, and that HALF_PERIOD is at least 3, so the synchronized value is settled by the next rising edge. The bench holds the mode fixed for each reset-bounded run. Its converter model moves the data line only on a falling clock or when its random conversion time ends. It keeps every conversion shorter than the wait bound, except for one directed case that holds the line high so the timeout path is exercised.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

  // Strobes from the sequencer to the datapath, valid for one system cycle.
  typedef struct packed {
    logic goAway;   // move sck off its resting level
    logic goHome;   // return sck to its resting level
    logic sample;   // shift the synchronized data bit into the word
    logic done;     // publish the assembled word
    logic errSet;   // wait ended on the bound, not on a ready edge
    logic errClr;   // wait ended on a ready edge
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_PHA  = 2'd1,
    ST_PHB  = 2'd2
  } ctrlState_e;

endpackage

// File: rtl/adc2w_datapath.sv
module adc2w_datapath
  import adc2w_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idleHigh,
  input  logic                 sdIn,
  input  ctrlStrobe_t          strobe,
  output logic                 sck,
  output logic                 sdFell,
  output logic [WORD_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 timeoutErr
);

  logic                 syncReg [SYNC_STAGES];
  logic                 sdSync;
  logic                 sdPrev;
  logic                 sckAway;
  logic [WORD_BITS-1:0] shiftReg;

  // Synchronizer chain, depth set by parameter.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[g] <= 1'b0;
        else       syncReg[g] <= sdIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[g] <= 1'b0;
        else       syncReg[g] <= syncReg[g-1];
      end
    end
  end

  assign sdSync = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sdPrev <= 1'b0;
    else       sdPrev <= sdSync;
  end

  assign sdFell = sdPrev & ~sdSync;

  // Serial clock: stored as "away from rest", so reset needs no mode value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sckAway <= 1'b0;
    else if (strobe.goAway) sckAway <= 1'b1;
    else if (strobe.goHome) sckAway <= 1'b0;
  end

  assign sck = sckAway ^ idleHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobe.sample) shiftReg <= {shiftReg[WORD_BITS-2:0], sdSync};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= strobe.done;
      if (strobe.done) dataOut <= shiftReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timeoutErr <= 1'b0;
    else if (strobe.errSet) timeoutErr <= 1'b1;
    else if (strobe.errClr) timeoutErr <= 1'b0;
  end

  // R2: a sample is always taken as sck goes high.
  p_sample_on_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sample |=> $rose(sck));

  // R2: the valid strobe never lasts more than one cycle.
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid);

  // R6: a word is published only while sck rests.
  p_home_at_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |-> (sck == idleHigh));

  // R7: the error flag belongs to the high-resting mode only.
  p_err_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> idleHigh);

endmodule

// File: rtl/adc2w_control.sv
module adc2w_control
  import adc2w_pkg::*;
#(
  parameter int WORD_BITS        = 16,
  parameter int HALF_PERIOD      = 50,
  parameter int CONV_WAIT_CYCLES = 3_400_000,
  parameter int TIMEOUT_CYCLES   = 4_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        idleHigh,
  input  logic        sdFell,
  output ctrlStrobe_t strobe
);

  localparam int HALF_W   = $clog2(HALF_PERIOD);
  localparam int WAIT_MAX = (CONV_WAIT_CYCLES > TIMEOUT_CYCLES) ? CONV_WAIT_CYCLES : TIMEOUT_CYCLES;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int BIT_W    = $clog2(WORD_BITS + 1);

  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(HALF_PERIOD - 1);
  localparam logic [WAIT_W-1:0] CONV_LAST = WAIT_W'(CONV_WAIT_CYCLES - 1);
  localparam logic [WAIT_W-1:0] TIME_LAST = WAIT_W'(TIMEOUT_CYCLES - 1);
  localparam logic [BIT_W-1:0]  WORD_END  = BIT_W'(WORD_BITS);

  ctrlState_e        state;
  logic [HALF_W-1:0] halfCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [BIT_W-1:0]  bitCnt;

  logic             halfEnd;
  logic             waitEnd;
  logic             startFrame;
  logic [BIT_W-1:0] lastPulse;

  // High-resting mode needs one extra pulse to restart the converter.
  assign lastPulse  = idleHigh ? WORD_END : WORD_END - BIT_W'(1);
  assign halfEnd    = (halfCnt == HALF_LAST);
  assign waitEnd    = idleHigh ? (waitCnt == TIME_LAST) : (waitCnt == CONV_LAST);
  assign startFrame = (state == ST_WAIT) && (idleHigh ? (sdFell || waitEnd) : waitEnd);

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_WAIT: begin
        if (startFrame) begin
          strobe.goAway = 1'b1;
          strobe.sample = !idleHigh;
          strobe.errClr = idleHigh && sdFell;
          strobe.errSet = idleHigh && !sdFell;
        end
      end
      ST_PHA: begin
        if (halfEnd) begin
          strobe.goHome = 1'b1;
          strobe.sample = idleHigh && (bitCnt < WORD_END);
        end
      end
      ST_PHB: begin
        if (halfEnd) begin
          if (bitCnt == lastPulse) begin
            strobe.done = 1'b1;
          end else begin
            strobe.goAway = 1'b1;
            strobe.sample = !idleHigh;
          end
        end
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAIT;
      halfCnt <= '0;
      waitCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        ST_WAIT: begin
          if (startFrame) begin
            state   <= ST_PHA;
            halfCnt <= '0;
            bitCnt  <= '0;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        ST_PHA: begin
          if (halfEnd) begin
            state   <= ST_PHB;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + HALF_W'(1);
          end
        end
        ST_PHB: begin
          if (halfEnd) begin
            halfCnt <= '0;
            if (bitCnt == lastPulse) begin
              state   <= ST_WAIT;
              waitCnt <= '0;
            end else begin
              state  <= ST_PHA;
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            halfCnt <= halfCnt + HALF_W'(1);
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  // R3: a ready edge seen while waiting in high-resting mode starts a frame.
  p_ready_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && idleHigh && sdFell) |=> (state == ST_PHA));

  // R3: the pulse index never passes the last pulse of the mode.
  p_pulse_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= lastPulse);

  // R5: a phase ends only on its final count.
  p_phase_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PHA && !halfEnd) |=> (state == ST_PHA));

  // R4: in low-resting mode a frame never starts before the wait count.
  p_wait_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !idleHigh && !waitEnd) |=> (state == ST_WAIT));

endmodule

// File: rtl/adc2w_reader.sv
module adc2w_reader
  import adc2w_pkg::*;
#(
  parameter int WORD_BITS        = 16,
  parameter int HALF_PERIOD      = 50,
  parameter int CONV_WAIT_CYCLES = 3_400_000,
  parameter int TIMEOUT_CYCLES   = 4_000_000,
  parameter int SYNC_STAGES      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idleHigh,
  input  logic                 sdIn,
  output logic                 sck,
  output logic [WORD_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 timeoutErr
);

  ctrlStrobe_t strobe;
  logic        sdFell;

  adc2w_control #(
    .WORD_BITS       (WORD_BITS),
    .HALF_PERIOD     (HALF_PERIOD),
    .CONV_WAIT_CYCLES(CONV_WAIT_CYCLES),
    .TIMEOUT_CYCLES  (TIMEOUT_CYCLES)
  ) i_control (
    .clk     (clk),
    .rstN    (rstN),
    .idleHigh(idleHigh),
    .sdFell  (sdFell),
    .strobe  (strobe)
  );

  adc2w_datapath #(
    .WORD_BITS  (WORD_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .idleHigh  (idleHigh),
    .sdIn      (sdIn),
    .strobe    (strobe),
    .sck       (sck),
    .sdFell    (sdFell),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .timeoutErr(timeoutErr)
  );

endmodule

// File: tb/test_adc2w_reader.sv
module test_adc2w_reader;

  localparam int W  = 16;
  localparam int HP = 4;
  localparam int CW = 200;
  localparam int TO = 400;
  localparam int FRAMES_PER_MODE = 20;

  logic         clk = 1'b0;
  logic         rstN;
  logic         idleHigh;
  logic         line;
  logic         stuck;
  logic         sdIn;
  logic         sck;
  logic [W-1:0] dataOut;
  logic         dataValid;
  logic         timeoutErr;

  assign sdIn = line | stuck;

  always #4 clk = ~clk;  // 125 MHz

  adc2w_reader #(
    .WORD_BITS       (W),
    .HALF_PERIOD     (HP),
    .CONV_WAIT_CYCLES(CW),
    .TIMEOUT_CYCLES  (TO),
    .SYNC_STAGES     (2)
  ) i_adc2w_reader (
    .clk       (clk),
    .rstN      (rstN),
    .idleHigh  (idleHigh),
    .sdIn      (sdIn),
    .sck       (sck),
    .dataOut   (dataOut),
    .dataValid (dataValid),
    .timeoutErr(timeoutErr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Converter model and monitors
  longint   cyc = 0;
  longint   lastEdgeCyc, lastValidCyc;
  int       falls, convLeft, framePulses, frames;
  bit       converting, stuckFrame, sckPrev, validPrev, hung;
  logic [W-1:0] word;

  function automatic logic [W-1:0] expectedWord(input bit fromStuck, input logic [W-1:0] w);
    return fromStuck ? {W{1'b1}} : w;
  endfunction

  initial begin
    stuck = 1'b0; line = 1'b0; hung = 1'b0; frames = 0;
  end

  always @(negedge clk) begin
    longint gap;
    cyc++;
    if (!rstN) begin
      sckPrev     = idleHigh;
      lastEdgeCyc = cyc;
      lastValidCyc = cyc;
      framePulses = 0;
      frames      = 0;
      falls       = 0;
      stuck       = 1'b0;
      stuckFrame  = 1'b0;
      validPrev   = 1'b0;
      converting  = 1'b1;
      word        = W'($urandom);
      convLeft    = idleHigh ? $urandom_range(300, 20) : $urandom_range(150, 50);
      line        = idleHigh;
    end else begin
      if (sck != sckPrev) begin
        gap = cyc - lastEdgeCyc;
        lastEdgeCyc = cyc;
        if (sck == idleHigh) begin
          check(gap == HP, "R5 phase length (home)", gap, HP);
        end else begin
          if (framePulses == 0) begin
            if (idleHigh) begin
              if (stuckFrame) check(cyc - lastValidCyc == TO, "R7 forced start after bound", cyc - lastValidCyc, TO);
              else            check(!converting, "R3 frame started before ready edge", converting, 0);
            end else if (frames > 0) begin
              check(gap == HP + CW, "R4 wait from last falling edge", gap, HP + CW);
            end
          end else begin
            check(gap == HP, "R5 phase length (away)", gap, HP);
          end
          framePulses++;
        end
        if (!idleHigh && sck) check(!converting, "R4 clock while converting", converting, 0);
        if (!sck) begin
          falls++;
          if (idleHigh) begin
            if (converting) begin
              if (falls == W + 1) begin
                falls = 0;
                convLeft = $urandom_range(300, 20);
              end
            end else if (falls <= W) begin
              line = word[W - falls];
            end else begin
              falls = 0;
              line = 1'b1;
              converting = 1'b1;
              convLeft = $urandom_range(300, 20);
            end
          end else begin
            if (falls < W) begin
              line = word[W - 1 - falls];
            end else begin
              falls = 0;
              converting = 1'b1;
              convLeft = $urandom_range(150, 50);
              line = 1'($urandom);
            end
          end
        end
        sckPrev = sck;
      end

      if (converting && !stuck) begin
        if (convLeft > 0) convLeft--;
        else begin
          converting = 1'b0;
          word = W'($urandom);
          if (frames == 3) word = 16'h8001;  // directed: both end bits set
          if (frames == 4) word = 16'h0000;  // directed: all clear
          line = idleHigh ? 1'b0 : word[W-1];
        end
      end

      if (validPrev) check(!dataValid, "R2 valid lasts one cycle", dataValid, 0);
      if (dataValid) begin
        check(dataOut == expectedWord(stuckFrame, word), "R2 word value", dataOut, expectedWord(stuckFrame, word));
        if (idleHigh) check(framePulses == W + 1, "R3 pulses per frame", framePulses, W + 1);
        else          check(framePulses == W, "R4 pulses per frame", framePulses, W);
        check(sck == idleHigh, "R6 resting level at valid", sck, idleHigh);
        check(timeoutErr == stuckFrame, "R7 error flag", timeoutErr, stuckFrame);
        frames++;
        framePulses = 0;
        lastValidCyc = cyc;
        if (stuckFrame) begin
          stuckFrame = 1'b0;
          stuck = 1'b0;
        end else if (idleHigh && frames == 8) begin
          stuckFrame = 1'b1;  // directed: hold the line high, no ready edge
          stuck = 1'b1;
        end
      end
      validPrev = dataValid;

      if (!hung && (cyc - lastValidCyc > 3000)) begin
        hung = 1'b1;
        check(1'b0, "R2 watchdog: no word delivered", cyc - lastValidCyc, 3000);
      end
    end
  end

  task automatic resetChecks();
    check(sck == idleHigh, "R1 sck at reset", sck, idleHigh);
    check(dataValid == 1'b0, "R1 valid at reset", dataValid, 0);
    check(dataOut == '0, "R1 data at reset", dataOut, 0);
    check(timeoutErr == 1'b0, "R1 error at reset", timeoutErr, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0;
    idleHigh = 1'b1;
    repeat (5) @(negedge clk);
    resetChecks();
    #2 rstN = 1'b1;
    while (frames < FRAMES_PER_MODE && !hung) @(posedge clk);

    @(negedge clk);
    #2 rstN = 1'b0;
    idleHigh = 1'b0;
    repeat (5) @(negedge clk);
    resetChecks();
    #2 rstN = 1'b1;
    while (frames < FRAMES_PER_MODE && !hung) @(posedge clk);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule